// File: doc/BRIEF.md
# Slot Reconfiguration Request Manager

This block coordinates the loading of configuration images into a set of reconfigurable slots (four by default). Each slot has its own manager. Software starts a load by writing a trigger and an image number to that slot's trigger input. The manager records the request, waits for the shared fetch engine, and reports its progress on a per-slot status output.

Only one fetch engine exists. Managers with a pending request wait for it, and a round-robin arbiter picks the next one. The engine takes the image's base address and word count from the image number. It reads the words one at a time from a memory-mapped store over a request/valid read port. Each word is then offered on a 32-bit valid/ready stream that feeds the configuration port, together with the target slot number and a last-word flag.

While a slot is being loaded, its outputs are isolated through a hold signal. The hold drops only after the final word has been accepted.

Top module: `recfg_mgr_top`

## Requirements
- R1: After reset every slot reports idle (status code 0), no slot is on hold, no slot has its reject flag set, and neither the memory read request nor the configuration stream is active.
- R2: A trigger for a slot whose status is idle (0) or done (3) moves that slot to queued (status code 1) at the next clock edge. It also clears that slot's reject flag.
- R3: A trigger for a slot whose status is queued (1) or loading (2) is rejected. The slot keeps its state and its stored image number, and its reject flag is set. The flag stays set until the slot next accepts a trigger.
- R4: Image k starts at word address k*IMG_STRIDE and is IMG_MIN_WORDS+k words long. Its words are streamed in ascending address order, and the last-word flag is set on the final word only.
- R5: At most one slot is loading (status code 2, hold asserted) at any time.
- R6: When several slots are queued, the fetch engine is granted round-robin. The search starts at the slot after the one granted most recently.
- R7: While a stream word is valid and not accepted, the data, slot number and last flag stay unchanged and valid stays high.
- R8: A slot's hold output is high for the whole time the slot is loading. In the cycle after its final word is accepted, the slot reports done (3) and the hold is low.
- R9: Every streamed word carries, on the slot output, the number of the slot being loaded.
- R10: Managers act independently: a slot accepts a trigger and becomes queued while another slot is loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid_i | input | NUM_SLOTS | One-cycle software trigger per slot |
| trig_img_i | input | NUM_SLOTS*IMG_W | Image number per slot, slot s in bits s*IMG_W upward |
| slot_state_o | output | NUM_SLOTS*2 | Status per slot: 0 idle, 1 queued, 2 loading, 3 done |
| slot_reject_o | output | NUM_SLOTS | Sticky flag: a trigger was refused |
| slot_hold_o | output | NUM_SLOTS | Slot outputs held inactive while loading |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | ADDR_W | Word address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| cfg_valid_o | output | 1 | Configuration word valid |
| cfg_ready_i | input | 1 | Configuration port accepts the word |
| cfg_data_o | output | DATA_W | Configuration word |
| cfg_last_o | output | 1 | Final word of the image |
| cfg_slot_o | output | IDX_W | Slot the word is meant for |

## Verification
A manager stuck in the wrong state shows up at the ports in one of three ways. Its status code differs on the very next edge after a trigger. Its hold bit stays high after its last word has been accepted. Or its stream words appear out of the expected service order, so the scoreboard sees a wrong slot number or a wrong data word within the first transfer. A corrupted round-robin pointer becomes visible at the first contended grant as a swapped image order. A wrong address or length counter appears as a data mismatch or a misplaced last flag, at the word where it goes wrong.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'd0,
        SLOT_QUEUED  = 2'd1,
        SLOT_LOADING = 2'd2,
        SLOT_DONE    = 2'd3
    } slot_state_e;

    typedef enum logic [1:0] {
        FE_IDLE = 2'd0,
        FE_READ = 2'd1,
        FE_PUSH = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/recfg_slot_mgr.sv
module recfg_slot_mgr
    import recfg_pkg::*;
#(
    parameter int IMG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [IMG_W-1:0] trig_img_i,
    input  logic             grant_i,
    input  logic             load_done_i,
    output logic [1:0]       state_o,
    output logic [IMG_W-1:0] img_o,
    output logic             reject_o,
    output logic             req_o,
    output logic             hold_o
);
    typedef struct packed {
        slot_state_e      st;
        logic [IMG_W-1:0] img;
        logic             rej;
    } mgr_t;

    mgr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SLOT_IDLE, SLOT_DONE: begin
                if (trig_i) begin
                    s_d.st  = SLOT_QUEUED;
                    s_d.img = trig_img_i;
                    s_d.rej = 1'b0;
                end
            end
            SLOT_QUEUED: begin
                if (trig_i)  s_d.rej = 1'b1;
                if (grant_i) s_d.st  = SLOT_LOADING;
            end
            SLOT_LOADING: begin
                if (trig_i)      s_d.rej = 1'b1;
                if (load_done_i) s_d.st  = SLOT_DONE;
            end
            default: s_d.st = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SLOT_IDLE, img: '0, rej: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state_o  = s_q.st;
    assign img_o    = s_q.img;
    assign reject_o = s_q.rej;
    assign req_o    = (s_q.st == SLOT_QUEUED);
    assign hold_o   = (s_q.st == SLOT_LOADING);

    // R3
    busy_trig_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && (s_q.st == SLOT_QUEUED || s_q.st == SLOT_LOADING))
        |=> (reject_o && img_o == $past(img_o)));

    // R8
    done_releases_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SLOT_LOADING && load_done_i) |=> (state_o == 2'd3 && !hold_o));
endmodule

// File: rtl/recfg_rr_arb.sv
module recfg_rr_arb #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             en_i,
    output logic [N-1:0]     gnt_o,
    output logic [IDX_W-1:0] gnt_idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } arb_t;

    arb_t a_d, a_q;
    logic found;
    int   j;

    always_comb begin
        a_d       = a_q;
        gnt_o     = '0;
        gnt_idx_o = '0;
        found     = 1'b0;
        j         = 0;
        for (int k = 0; k < N; k++) begin
            j = (int'(a_q.ptr) + k) % N;
            if (!found && req_i[j]) begin
                found     = 1'b1;
                gnt_idx_o = IDX_W'(j);
            end
        end
        if (en_i && found) begin
            gnt_o[gnt_idx_o] = 1'b1;
            a_d.ptr = (gnt_idx_o == IDX_W'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    // R6
    grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/recfg_fetch.sv
module recfg_fetch
    import recfg_pkg::*;
#(
    parameter int N             = 4,
    parameter int IMG_W         = 2,
    parameter int ADDR_W        = 12,
    parameter int LEN_W         = 6,
    parameter int DATA_W        = 32,
    parameter int IMG_STRIDE    = 64,
    parameter int IMG_MIN_WORDS = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [IDX_W-1:0]  start_slot_i,
    input  logic [IMG_W-1:0]  start_img_i,
    output logic              idle_o,
    output logic              done_o,
    output logic [IDX_W-1:0]  cur_slot_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              cfg_valid_o,
    input  logic              cfg_ready_i,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_last_o
);
    typedef struct packed {
        fetch_state_e      st;
        logic [IDX_W-1:0]  slot;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic [DATA_W-1:0] data;
    } fe_t;

    fe_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            FE_IDLE: begin
                if (start_i) begin
                    f_d.st     = FE_READ;
                    f_d.slot   = start_slot_i;
                    f_d.addr   = ADDR_W'(start_img_i) * ADDR_W'(IMG_STRIDE);
                    f_d.remain = LEN_W'(IMG_MIN_WORDS) + LEN_W'(start_img_i) - LEN_W'(1);
                end
            end
            FE_READ: begin
                if (mem_rvalid_i) begin
                    f_d.data = mem_rdata_i;
                    f_d.st   = FE_PUSH;
                end
            end
            FE_PUSH: begin
                if (cfg_ready_i) begin
                    if (f_q.remain == '0) begin
                        f_d.st = FE_IDLE;
                    end else begin
                        f_d.addr   = f_q.addr + 1'b1;
                        f_d.remain = f_q.remain - 1'b1;
                        f_d.st     = FE_READ;
                    end
                end
            end
            default: f_d.st = FE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{st: FE_IDLE, slot: '0, addr: '0, remain: '0, data: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign idle_o      = (f_q.st == FE_IDLE);
    assign mem_req_o   = (f_q.st == FE_READ);
    assign mem_addr_o  = f_q.addr;
    assign cfg_valid_o = (f_q.st == FE_PUSH);
    assign cfg_data_o  = f_q.data;
    assign cfg_last_o  = cfg_valid_o && (f_q.remain == '0);
    assign cur_slot_o  = f_q.slot;
    assign done_o      = cfg_valid_o && cfg_ready_i && (f_q.remain == '0);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && !cfg_ready_i)
        |=> (cfg_valid_o && $stable(cfg_data_o) && $stable(cur_slot_o) && $stable(cfg_last_o)));

    // R4
    next_word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid_o && cfg_ready_i && !cfg_last_o)
        |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

// File: rtl/recfg_mgr_top.sv
module recfg_mgr_top
    import recfg_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int IMG_W         = 2,
    parameter int ADDR_W        = 12,
    parameter int LEN_W         = 6,
    parameter int DATA_W        = 32,
    parameter int IMG_STRIDE    = 64,
    parameter int IMG_MIN_WORDS = 3,
    localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SLOTS-1:0]       trig_valid_i,
    input  logic [NUM_SLOTS*IMG_W-1:0] trig_img_i,
    output logic [NUM_SLOTS*2-1:0]     slot_state_o,
    output logic [NUM_SLOTS-1:0]       slot_reject_o,
    output logic [NUM_SLOTS-1:0]       slot_hold_o,
    output logic                       mem_req_o,
    output logic [ADDR_W-1:0]          mem_addr_o,
    input  logic                       mem_rvalid_i,
    input  logic [DATA_W-1:0]          mem_rdata_i,
    output logic                       cfg_valid_o,
    input  logic                       cfg_ready_i,
    output logic [DATA_W-1:0]          cfg_data_o,
    output logic                       cfg_last_o,
    output logic [IDX_W-1:0]           cfg_slot_o
);
    logic [NUM_SLOTS-1:0] req_v;
    logic [NUM_SLOTS-1:0] gnt_v;
    logic [NUM_SLOTS-1:0] done_v;
    logic [IMG_W-1:0]     img_a [NUM_SLOTS];
    logic [IDX_W-1:0]     gnt_idx;
    logic                 fe_idle;
    logic                 fe_done;
    logic [IDX_W-1:0]     fe_slot;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign done_v[s] = fe_done && (fe_slot == IDX_W'(s));
        recfg_slot_mgr #(.IMG_W(IMG_W)) u_mgr (
            .clk         (clk),
            .rst_n       (rst_n),
            .trig_i      (trig_valid_i[s]),
            .trig_img_i  (trig_img_i[s*IMG_W +: IMG_W]),
            .grant_i     (gnt_v[s]),
            .load_done_i (done_v[s]),
            .state_o     (slot_state_o[s*2 +: 2]),
            .img_o       (img_a[s]),
            .reject_o    (slot_reject_o[s]),
            .req_o       (req_v[s]),
            .hold_o      (slot_hold_o[s])
        );
    end

    recfg_rr_arb #(.N(NUM_SLOTS)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_v),
        .en_i      (fe_idle),
        .gnt_o     (gnt_v),
        .gnt_idx_o (gnt_idx)
    );

    recfg_fetch #(
        .N             (NUM_SLOTS),
        .IMG_W         (IMG_W),
        .ADDR_W        (ADDR_W),
        .LEN_W         (LEN_W),
        .DATA_W        (DATA_W),
        .IMG_STRIDE    (IMG_STRIDE),
        .IMG_MIN_WORDS (IMG_MIN_WORDS)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (|gnt_v),
        .start_slot_i (gnt_idx),
        .start_img_i  (img_a[gnt_idx]),
        .idle_o       (fe_idle),
        .done_o       (fe_done),
        .cur_slot_o   (fe_slot),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .cfg_valid_o  (cfg_valid_o),
        .cfg_ready_i  (cfg_ready_i),
        .cfg_data_o   (cfg_data_o),
        .cfg_last_o   (cfg_last_o)
    );

    assign cfg_slot_o = fe_slot;

    // R5
    single_loader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_hold_o));

    // R9
    word_targets_loader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> slot_hold_o[cfg_slot_o]);
endmodule

// File: tb/tb_recfg_mgr_top.sv
module tb_recfg_mgr_top;
    localparam int NS = 4, IW = 2, AW = 12, LW = 6, DW = 32, STRIDE = 64, MINW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NS-1:0]    trig_valid = '0;
    logic [NS*IW-1:0] trig_img = '0;
    logic [NS*2-1:0]  slot_state;
    logic [NS-1:0]    slot_reject, slot_hold;
    logic             mem_req, mem_rvalid;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_rdata;
    logic             cfg_valid, cfg_last;
    logic             cfg_ready = 1'b1;
    logic [DW-1:0]    cfg_data;
    logic [1:0]       cfg_slot;

    int tests_run = 0, tests_failed = 0;
    logic [34:0] exp_q[$];
    int rr_next = 0;
    int timg [NS];
    logic bp_on = 1'b0;
    int bp_cnt = 0;
    logic r5_bad = 1'b0;
    int done_chk_slot = -1;
    logic prev_stall = 1'b0;
    logic [34:0] prev_word = '0;

    recfg_mgr_top dut (
        .clk(clk), .rst_n(rst_n), .trig_valid_i(trig_valid), .trig_img_i(trig_img),
        .slot_state_o(slot_state), .slot_reject_o(slot_reject), .slot_hold_o(slot_hold),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .cfg_valid_o(cfg_valid), .cfg_ready_i(cfg_ready),
        .cfg_data_o(cfg_data), .cfg_last_o(cfg_last), .cfg_slot_o(cfg_slot)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
        end else begin
            mem_rvalid <= mem_req && !mem_rvalid;
            mem_rdata  <= 32'hC0DE_0000 | 32'(mem_addr);
        end
    end

    // ready pattern, changed just after the edge
    always @(posedge clk) begin
        #1;
        bp_cnt++;
        cfg_ready = bp_on ? (bp_cnt % 3 == 0) : 1'b1;
    end

    function automatic logic [31:0] word_of(int img, int w);
        return 32'hC0DE_0000 | 32'(img * STRIDE + w);
    endfunction

    function automatic logic [1:0] st_of(int s);
        return slot_state[s*2 +: 2];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests_run++;
        if (!ok) begin
            tests_failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_image(input int s, input int img);
        for (int w = 0; w < MINW + img; w++)
            exp_q.push_back({2'(s), (w == MINW + img - 1), word_of(img, w)});
    endtask

    task automatic expect_order(input logic [NS-1:0] mask);
        int last_s;
        last_s = -1;
        for (int k = 0; k < NS; k++) begin
            int s;
            s = (rr_next + k) % NS;
            if (mask[s]) begin
                push_image(s, timg[s]);
                last_s = s;
            end
        end
        if (last_s >= 0) rr_next = (last_s + 1) % NS;
    endtask

    task automatic fire(input logic [NS-1:0] mask);
        @(negedge clk);
        for (int s = 0; s < NS; s++) begin
            if (mask[s]) begin
                trig_valid[s] = 1'b1;
                trig_img[s*IW +: IW] = IW'(timg[s]);
            end
        end
        @(negedge clk);
        trig_valid = '0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, "R4", "stream drained", 64'(exp_q.size()), 64'd0);
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_chk_slot >= 0) begin
                // R8: done and released the cycle after the last word
                check(st_of(done_chk_slot) == 2'd3 && !slot_hold[done_chk_slot], "R8",
                      "done after last word", {62'd0, st_of(done_chk_slot)}, 64'd3);
                done_chk_slot = -1;
            end
            if ($countones(slot_hold) > 1) r5_bad = 1'b1;
            if (prev_stall) begin
                // R7: stalled word held
                check(cfg_valid && {cfg_slot, cfg_last, cfg_data} == prev_word, "R7",
                      "stalled word stable", 64'({cfg_slot, cfg_last, cfg_data}), 64'(prev_word));
            end
            if (cfg_valid && cfg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected word", 64'(cfg_data), 64'd0);
                end else begin
                    logic [34:0] e;
                    e = exp_q.pop_front();
                    // R4 data/last, R9 slot
                    check({cfg_slot, cfg_last, cfg_data} == e, "R4/R9",
                          "word slot,last,data", 64'({cfg_slot, cfg_last, cfg_data}), 64'(e));
                    check(slot_hold[cfg_slot], "R8", "hold during load",
                          64'(slot_hold), 64'(1 << cfg_slot));
                end
                if (cfg_last) done_chk_slot = int'(cfg_slot);
            end
            prev_stall = cfg_valid && !cfg_ready;
            prev_word  = {cfg_slot, cfg_last, cfg_data};
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int s = 0; s < NS; s++) timg[s] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(slot_state == '0, "R1", "status idle", 64'(slot_state), 64'd0);
        check(slot_hold == '0 && slot_reject == '0, "R1", "hold/reject",
              64'({slot_hold, slot_reject}), 64'd0);
        check(!cfg_valid && !mem_req, "R1", "stream/mem idle", 64'({cfg_valid, mem_req}), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // single load of slot 1 with image 2
        timg[1] = 2;
        expect_order(4'b0010);
        fire(4'b0010);
        check(st_of(1) == 2'd1, "R2", "slot1 queued", 64'(st_of(1)), 64'd1);
        @(negedge clk);
        check(st_of(1) == 2'd2 && slot_hold[1], "R8", "slot1 loading+hold",
              64'({slot_hold[1], st_of(1)}), 64'h6);
        drain();

        // reject and independence
        timg[0] = 1;
        expect_order(4'b0001);
        fire(4'b0001);
        @(negedge clk);
        check(st_of(0) == 2'd2, "R3", "slot0 loading", 64'(st_of(0)), 64'd2);
        timg[0] = 3;
        fire(4'b0001);
        check(slot_reject[0] && st_of(0) == 2'd2, "R3", "busy trigger refused",
              64'({slot_reject[0], st_of(0)}), 64'h6);
        timg[2] = 0;
        expect_order(4'b0100);
        fire(4'b0100);
        // R10: another slot accepts while slot 0 loads
        check(st_of(2) == 2'd1 && st_of(0) == 2'd2, "R10", "slot2 queued during load",
              64'({st_of(2), st_of(0)}), 64'h6);
        drain();
        check(st_of(0) == 2'd3 && slot_reject[0], "R3", "reject sticky",
              64'({slot_reject[0], st_of(0)}), 64'h7);
        timg[0] = 0;
        expect_order(4'b0001);
        fire(4'b0001);
        check(!slot_reject[0] && st_of(0) == 2'd1, "R2", "accept clears reject",
              64'({slot_reject[0], st_of(0)}), 64'h1);
        drain();

        // all four at once with backpressure
        bp_on = 1'b1;
        for (int s = 0; s < NS; s++) timg[s] = s;
        expect_order(4'b1111);
        fire(4'b1111);
        check(slot_state == 8'h55, "R2", "all queued", 64'(slot_state), 64'h55);
        drain();
        bp_on = 1'b0;

        // R6: rotation after slot 2
        timg[2] = 1;
        expect_order(4'b0100);
        fire(4'b0100);
        timg[1] = 2;
        timg[3] = 0;
        expect_order(4'b1010);
        fire(4'b1010);
        drain();

        check(slot_state == 8'hFF, "R8", "all done", 64'(slot_state), 64'hFF);
        // R5
        check(!r5_bad, "R5", "single loader", 64'(r5_bad), 64'd0);
        check(exp_q.size() == 0, "R6", "service order complete", 64'(exp_q.size()), 64'd0);
        finish_run();
    end
endmodule